// File: doc/BRIEF.md
# SONET Path Overhead Monitor

This block watches one SONET path carried as a byte stream. Each byte comes with three marker inputs. One marks the first byte of the synchronous payload envelope (the J1 byte), one marks the path parity byte (B3) and one marks the path status byte (G1). From one start marker to the next, the block forms an eight-bit interleaved parity. It then checks that parity against the B3 byte that arrives in the following frame. A mismatch produces a one-cycle error pulse.

The block also decodes the G1 byte. The upper four bits give a far-end receive failure alarm, which tracks the code in every frame. The remote defect bit passes through a persistence filter that needs ten agreeing frames before the alarm changes in either direction. The three events set sticky status bits. Software clears these bits by writing ones. An active-low interrupt line combines the sticky bits through a per-bit enable mask.

Top module: `path_oh_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, bip_err, ferf_alarm and rdi_alarm are 0, stat_sticky is 000 and irq_n is 1.
- R2: The parity of a frame is the bitwise XOR of every byte accepted with in_valid high. The first such byte is the one flagged by in_j1, and the last is the byte just before the next in_j1. Cycles with in_valid low are ignored together with their data and markers, and the frame length may vary.
- R3: At a byte flagged by in_b3, the byte value is compared with the parity of the previous complete frame. On a mismatch, bip_err is high for exactly the one cycle that follows that byte.
- R4: After reset, no comparison is made until one complete frame has closed. This means the B3 byte of the first frame never raises bip_err.
- R5: ferf_alarm is 1 when the most recent G1 byte has bits [7:4] equal to 4'b1001, and 0 for any other value. Bit 7 is G1 bit 1. The alarm is updated on the cycle after the G1 byte, and bits [3:0] have no effect on it.
- R6: The defect bit is G1 data bit [3]. rdi_alarm becomes 1 after the bit has been 1 in RDI_PERSIST (10) consecutive G1 bytes, and becomes 0 after it has been 0 in 10 consecutive G1 bytes. Any change of the bit restarts the count.
- R7: stat_sticky[0] is set by a bip_err pulse. Bit [1] is set by a rising ferf_alarm and bit [2] by a rising rdi_alarm, each one cycle after its cause. A bit stays set until a cycle with the matching stat_clr bit high. If a set and a clear occur in the same cycle, the set wins.
- R8: irq_n is 0 exactly when some bit of stat_sticky is 1 with the same bit of irq_en also 1. A masked sticky bit still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Stream byte |
| in_j1 | input | 1 | Marks the first envelope byte |
| in_b3 | input | 1 | Marks the path parity byte |
| in_g1 | input | 1 | Marks the path status byte |
| irq_en | input | 3 | Interrupt enable per sticky bit |
| stat_clr | input | 3 | Write-one-to-clear strobe per sticky bit |
| bip_err | output | 1 | One-cycle parity mismatch pulse |
| ferf_alarm | output | 1 | Far-end receive failure level |
| rdi_alarm | output | 1 | Filtered remote defect level |
| stat_sticky | output | 3 | Sticky status: [0] parity, [1] FERF, [2] RDI |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several rules on every cycle. An error pulse may follow only a parity byte, and it always leaves its sticky bit set and, when enabled, the interrupt line low. Either alarm may change only after a G1 byte. A sticky bit may never fall without its clear strobe. The bench scenarios cover what depends on counting over frames: the parity value itself over frames of different lengths with idle gaps, the silence of the first frame after reset, the ten-frame set and clear of the defect alarm with its restart on a change of the bit, and the effect of the interrupt mask.

// File: rtl/pom_pkg.sv
package pom_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_STAT = 3;

    // sticky status positions
    localparam int ST_BIP  = 0;
    localparam int ST_FERF = 1;
    localparam int ST_RDI  = 2;

    localparam logic [3:0] FERF_CODE = 4'b1001;
    localparam int         RDI_BIT   = 3;

    typedef struct packed {
        logic              valid;
        logic              j1;
        logic              b3;
        logic              g1;
        logic [BYTE_W-1:0] data;
    } pom_beat_t;

    function automatic logic g1_is_ferf(input logic [BYTE_W-1:0] g1);
        return g1[BYTE_W-1 -: 4] == FERF_CODE;
    endfunction

    function automatic logic g1_defect_bit(input logic [BYTE_W-1:0] g1);
        return g1[RDI_BIT];
    endfunction
endpackage

// File: rtl/pom_bip8.sv
module pom_bip8
    import pom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pom_beat_t beat,
    output logic      err
);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] ref_par;
    logic              in_frame;
    logic              ref_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            ref_par  <= '0;
            in_frame <= 1'b0;
            ref_ok   <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            if (beat.valid) begin
                if (beat.b3 && ref_ok && (beat.data != ref_par))
                    err <= 1'b1;
                if (beat.j1) begin
                    acc      <= beat.data;
                    in_frame <= 1'b1;
                    if (in_frame) begin
                        ref_par <= acc;
                        ref_ok  <= 1'b1;
                    end
                end else begin
                    acc <= acc ^ beat.data;
                end
            end
        end
    end
endmodule

// File: rtl/pom_g1_mon.sv
module pom_g1_mon
    import pom_pkg::*;
#(
    parameter int PERSIST = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  pom_beat_t beat,
    output logic      ferf,
    output logic      rdi
);
    localparam int CW = $clog2(PERSIST + 1);

    logic          run_val;
    logic [CW-1:0] run_cnt;
    logic          bit_now;
    logic [CW-1:0] nxt_cnt;

    always_comb begin
        bit_now = g1_defect_bit(beat.data);
        if (bit_now != run_val)
            nxt_cnt = CW'(1);
        else if (run_cnt == CW'(PERSIST))
            nxt_cnt = run_cnt;
        else
            nxt_cnt = run_cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ferf    <= 1'b0;
            rdi     <= 1'b0;
            run_val <= 1'b0;
            run_cnt <= '0;
        end else if (beat.valid && beat.g1) begin
            ferf    <= g1_is_ferf(beat.data);
            run_val <= bit_now;
            run_cnt <= nxt_cnt;
            if (nxt_cnt == CW'(PERSIST))
                rdi <= bit_now;
        end
    end
endmodule

// File: rtl/pom_status.sv
module pom_status #(
    parameter int               N         = 3,
    parameter logic [N-1:0]     EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sticky
);
    logic [N-1:0] src_d;
    logic [N-1:0] set_ev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            assign set_ev[i] = src[i] & ~src_d[i];
        end else begin : g_pulse
            assign set_ev[i] = src[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_d  <= '0;
            sticky <= '0;
        end else begin
            src_d  <= src;
            sticky <= (sticky & ~clr) | set_ev;
        end
    end
endmodule

// File: rtl/path_oh_monitor.sv
module path_oh_monitor
    import pom_pkg::*;
#(
    parameter int RDI_PERSIST = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_j1,
    input  logic                in_b3,
    input  logic                in_g1,
    input  logic [NUM_STAT-1:0] irq_en,
    input  logic [NUM_STAT-1:0] stat_clr,
    output logic                bip_err,
    output logic                ferf_alarm,
    output logic                rdi_alarm,
    output logic [NUM_STAT-1:0] stat_sticky,
    output logic                irq_n
);
    localparam logic [NUM_STAT-1:0] EDGE_BITS =
        NUM_STAT'((1 << ST_FERF) | (1 << ST_RDI));

    pom_beat_t            beat;
    logic [NUM_STAT-1:0]  stat_src;

    assign beat = '{valid: in_valid, j1: in_j1, b3: in_b3, g1: in_g1, data: in_data};

    pom_bip8 u_bip (
        .clk (clk),
        .rst (rst),
        .beat(beat),
        .err (bip_err)
    );

    pom_g1_mon #(.PERSIST(RDI_PERSIST)) u_g1 (
        .clk (clk),
        .rst (rst),
        .beat(beat),
        .ferf(ferf_alarm),
        .rdi (rdi_alarm)
    );

    always_comb begin
        stat_src          = '0;
        stat_src[ST_BIP]  = bip_err;
        stat_src[ST_FERF] = ferf_alarm;
        stat_src[ST_RDI]  = rdi_alarm;
    end

    pom_status #(.N(NUM_STAT), .EDGE_MASK(EDGE_BITS)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .src   (stat_src),
        .clr   (stat_clr),
        .sticky(stat_sticky)
    );

    assign irq_n = ~|(stat_sticky & irq_en);
endmodule

// File: rtl/path_oh_monitor_chk.sv
module path_oh_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_b3,
    input logic       in_g1,
    input logic [2:0] irq_en,
    input logic [2:0] stat_clr,
    input logic       bip_err,
    input logic       ferf_alarm,
    input logic       rdi_alarm,
    input logic [2:0] stat_sticky,
    input logic       irq_n
);
    // R3
    bip_after_b3_chk: assert property (@(posedge clk) disable iff (rst)
        bip_err |-> $past(in_valid && in_b3));

    // R5
    ferf_on_g1_chk: assert property (@(posedge clk) disable iff (rst)
        (ferf_alarm != $past(ferf_alarm)) |-> $past(in_valid && in_g1));

    // R6
    rdi_on_g1_chk: assert property (@(posedge clk) disable iff (rst)
        (rdi_alarm != $past(rdi_alarm)) |-> $past(in_valid && in_g1));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(stat_sticky) & ~stat_sticky) & ~$past(stat_clr)) == 3'b000));

    // R7
    bip_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bip_err |=> stat_sticky[0]);

    // R8
    bip_irq_chk: assert property (@(posedge clk) disable iff (rst)
        bip_err ##1 irq_en[0] |-> !irq_n);
endmodule

bind path_oh_monitor path_oh_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_b3      (in_b3),
    .in_g1      (in_g1),
    .irq_en     (irq_en),
    .stat_clr   (stat_clr),
    .bip_err    (bip_err),
    .ferf_alarm (ferf_alarm),
    .rdi_alarm  (rdi_alarm),
    .stat_sticky(stat_sticky),
    .irq_n      (irq_n)
);

// File: tb/path_oh_monitor_test.sv
module path_oh_monitor_test;
    localparam int CLK_P = 10;
    localparam int NVEC  = 16;
    // {g1[7:0], corrupt_b3, exp_err, exp_ferf, exp_rdi}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h008, 12'h000, 12'h00C, 12'h902, 12'h800, 12'h9F2, 12'h080, 12'h080,
        12'h08C, 12'h080, 12'h080, 12'h080, 12'h080, 12'h080, 12'h081, 12'h001
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_j1 = 1'b0, in_b3 = 1'b0, in_g1 = 1'b0;
    logic [2:0] irq_en = 3'b111;
    logic [2:0] stat_clr = 3'b000;
    logic       bip_err, ferf_alarm, rdi_alarm, irq_n;
    logic [2:0] stat_sticky;

    int total = 0;
    int bad   = 0;
    int err_seen = 0;
    int fr = 0;
    logic [7:0] prev_par = '0;

    always #(CLK_P/2) clk = ~clk;

    path_oh_monitor uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_j1(in_j1), .in_b3(in_b3), .in_g1(in_g1), .irq_en(irq_en),
        .stat_clr(stat_clr), .bip_err(bip_err), .ferf_alarm(ferf_alarm),
        .rdi_alarm(rdi_alarm), .stat_sticky(stat_sticky), .irq_n(irq_n)
    );

    always @(negedge clk) if (!rst && bip_err) err_seen++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic [7:0] d,
                       input logic j, input logic b, input logic g);
        @(negedge clk);
        in_valid = v; in_data = d; in_j1 = j; in_b3 = b; in_g1 = g;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input logic [7:0] g1, input logic corrupt,
                              input int len, input logic gaps);
        logic [7:0] cur = '0;
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            if (i == 0)      d = 8'h5A ^ 8'(fr);
            else if (i == 2) d = corrupt ? ~prev_par : prev_par;
            else if (i == 3) d = g1;
            else             d = 8'(i * 37 + fr * 11 + 5);
            cur ^= d;
            put(1'b1, d, i == 0, i == 2, i == 3);
            // ignored cycle: garbage data with every marker raised
            if (gaps && (i % 3 == 0)) put(1'b0, 8'hFF, 1'b1, 1'b1, 1'b1);
        end
        prev_par = cur;
        fr++;
        idle(2);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        @(negedge clk) stat_clr = m;
        @(negedge clk) stat_clr = 3'b000;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0;
        idle(3);
        // R1: outputs while in reset
        check("R1 bip_err in reset", int'(bip_err), 0);
        check("R1 irq_n in reset", int'(irq_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sticky after reset", int'(stat_sticky), 0);
        check("R1 alarms after reset", int'({ferf_alarm, rdi_alarm}), 0);

        // table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            e0 = err_seen;
            send_frame(VEC[k][11:4], VEC[k][3], 20, 1'b0);
            check($sformatf("R3/R4 err frame %0d", k), err_seen - e0, int'(VEC[k][2]));
            check($sformatf("R5 ferf frame %0d", k), int'(ferf_alarm), int'(VEC[k][1]));
            check($sformatf("R6 rdi frame %0d", k), int'(rdi_alarm), int'(VEC[k][0]));
        end

        // R7 / R8: all events seen, all enabled
        check("R7 sticky all set", int'(stat_sticky), 7);
        check("R8 irq asserted", int'(irq_n), 0);
        pulse_clr(3'b001);
        check("R7 clear bit0 only", int'(stat_sticky), 6);
        check("R8 irq still low", int'(irq_n), 0);
        pulse_clr(3'b110);
        check("R7 clear rest", int'(stat_sticky), 0);
        check("R8 irq released", int'(irq_n), 1);

        // R8: masked sticky bit
        irq_en = 3'b110;
        send_frame(8'h00, 1'b1, 20, 1'b0);
        check("R8 masked sticky set", int'(stat_sticky), 1);
        check("R8 masked irq high", int'(irq_n), 1);
        @(negedge clk) irq_en = 3'b111;
        @(negedge clk);
        check("R8 unmasked irq low", int'(irq_n), 0);
        pulse_clr(3'b111);

        // R2: other lengths and ignored gap cycles
        e0 = err_seen;
        send_frame(8'h00, 1'b0, 27, 1'b1);
        send_frame(8'h00, 1'b0, 15, 1'b1);
        check("R2 gapped frames no error", err_seen - e0, 0);
        e0 = err_seen;
        send_frame(8'h00, 1'b1, 15, 1'b1);
        check("R2 gapped corrupt detected", err_seen - e0, 1);

        // R6: a single one restarts the zero count
        send_frame(8'h08, 1'b0, 20, 1'b0);
        for (int i = 0; i < 9; i++) send_frame(8'h00, 1'b0, 20, 1'b0);
        check("R6 restart holds rdi at 9 zeros", int'(rdi_alarm), 1);
        send_frame(8'h00, 1'b0, 20, 1'b0);
        check("R6 rdi clears at 10 zeros", int'(rdi_alarm), 0);

        // R4: reset mid-stream forgets reference parity
        do_reset();
        check("R1 sticky after mid reset", int'(stat_sticky), 0);
        e0 = err_seen;
        send_frame(8'h00, 1'b1, 20, 1'b0);
        check("R4 first frame after reset silent", err_seen - e0, 0);
        send_frame(8'h00, 1'b1, 20, 1'b0);
        check("R3 second frame corrupt", err_seen - e0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule